// File: doc/BRIEF.md
# ADC Conversion and Readout Sequencer

This block drives the control lines of a parallel-output analog-to-digital converter from a fixed step pattern. Each conversion cycle lasts a set number of steps. A conversion-start line goes low at the top of the cycle. The rising edge of that line starts the conversion. A stimulus clock for the signal source rises one step later. After a fixed conversion wait, chip select and read go low together for a short window. The parallel word is latched at the end of that window.

The latched word is reduced to the converter's width by an AND mask. Its most significant bit is then flipped, which turns two's complement into straight (offset) binary. The result appears on the sample output with a one-clock valid pulse. A run starts with a start pulse and a conversion count. It performs that many back-to-back cycles and ends with a one-clock done pulse. The default timing assumes one 10 ns step per clock at 100 MHz: 204 steps per cycle, 4 steps of conversion start, 165 steps of conversion wait, 3 read steps, then 32 further steps before the next cycle begins.

Top module: `adc_strobe_seq`

## Requirements
- R1: After reset and whenever no run is active, conv_start_n, chip_sel_n and read_n are high, stim_clk is low, and busy, done and sample_valid are low.
- R2: A start pulse seen while busy is low, with a non-zero count, sets busy and drives conv_start_n low in the very next clock for 4 steps. Each later cycle starts 204 steps after the previous one.
- R3: chip_sel_n and read_n fall together 165 steps after conv_start_n rises, and rise together 3 steps later.
- R4: stim_clk rises one step after conv_start_n rises and stays high for 100 steps.
- R5: The input word is latched at the end of the last read step. sample_valid is high for exactly one clock, in the step after the latch.
- R6: sample equals (latched word AND 24'h000FFF) XOR 24'h000800, so bits 23..12 are always zero and the sign bit (bit 11) is flipped.
- R7: A run with count N produces exactly N sample_valid pulses. A run with count 0 produces no strobe activity and only a done pulse in the next clock.
- R8: done is high for exactly one clock, the clock after the last sample_valid. busy falls in that same clock.
- R9: A start pulse while busy is high is ignored: the run length and the strobe timing of the current run do not change.
- R10: A synchronous reset in the middle of a run returns every output to its idle level in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one step per clock by default |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock request to begin a run |
| conv_count | input | 20 | Number of conversions in the run |
| adc_data | input | 24 | Parallel capture word from the converter |
| conv_start_n | output | 1 | Active-low conversion start |
| chip_sel_n | output | 1 | Active-low chip select |
| read_n | output | 1 | Active-low read |
| stim_clk | output | 1 | Stimulus update clock for the signal source |
| sample | output | 24 | Masked, offset-binary sample |
| sample_valid | output | 1 | One-clock pulse when sample is new |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-clock pulse at the end of a run |

## Verification
A step counter that is off by even one position moves the read window relative to conversion start. This shows up as a wrong step count in the first cycle, within about 170 clocks of start. A wrong remaining-count register shows up only at the end of a run, as an extra or missing sample_valid or a misplaced done. For that reason, runs of 1, 2 and 4 conversions are compared clock by clock against a waveform the bench computes itself. A data-path fault, such as a missing mask or a flipped sign bit, shows at the first sample_valid. The input words are chosen to sit at the two's complement extremes and to carry set upper bits.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Number of bits needed to hold values 0..n-1 (at least 1)
  function automatic int idx_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  import adc_seq_pkg::*;

  localparam int DW = idx_bits(TICK_DIV);
  localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CYCLE_STEPS     = 204,
  parameter int CONV_LOW_STEPS  = 4,
  parameter int CONV_TIME_STEPS = 165,
  parameter int READ_STEPS      = 3,
  parameter int STIM_DELAY      = 1,
  parameter int STIM_HIGH_STEPS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run_q,
  input  logic run_d,
  input  logic run_start,
  output logic cap_evt,
  output logic conv_start_n,
  output logic chip_sel_n,
  output logic read_n,
  output logic stim_clk
);
  import adc_seq_pkg::*;

  localparam int SW = idx_bits(CYCLE_STEPS);
  localparam logic [SW-1:0] STEP_LAST = SW'(CYCLE_STEPS - 1);
  localparam logic [SW-1:0] CONV_END  = SW'(CONV_LOW_STEPS);
  localparam logic [SW-1:0] RD_BEGIN  = SW'(CONV_LOW_STEPS + CONV_TIME_STEPS);
  localparam logic [SW-1:0] RD_END    = SW'(CONV_LOW_STEPS + CONV_TIME_STEPS + READ_STEPS);
  localparam logic [SW-1:0] CAP_STEP  = SW'(CONV_LOW_STEPS + CONV_TIME_STEPS + READ_STEPS - 1);
  localparam logic [SW-1:0] STIM_ON   = SW'(CONV_LOW_STEPS + STIM_DELAY);
  localparam logic [SW-1:0] STIM_OFF  = SW'(CONV_LOW_STEPS + STIM_DELAY + STIM_HIGH_STEPS);

  logic [SW-1:0] step_q, step_d;

  always_comb begin
    step_d = step_q;
    if (!run_d || run_start) step_d = '0;
    else if (tick)           step_d = (step_q == STEP_LAST) ? '0 : step_q + 1'b1;
  end

  assign cap_evt = run_q && tick && (step_q == CAP_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q       <= '0;
      conv_start_n <= 1'b1;
      chip_sel_n   <= 1'b1;
      read_n       <= 1'b1;
      stim_clk     <= 1'b0;
    end else begin
      step_q       <= step_d;
      conv_start_n <= !(run_d && (step_d < CONV_END));
      chip_sel_n   <= !(run_d && (step_d >= RD_BEGIN) && (step_d < RD_END));
      read_n       <= !(run_d && (step_d >= RD_BEGIN) && (step_d < RD_END));
      stim_clk     <= run_d && (step_d >= STIM_ON) && (step_d < STIM_OFF);
    end
  end

  // R3
  no_convst_during_read_chk: assert property (@(posedge clk) disable iff (rst)
    !(!conv_start_n && !chip_sel_n));

  // R3
  read_after_convst_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(read_n) |-> conv_start_n);

  // R4
  stim_after_convst_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stim_clk) |-> conv_start_n && $past(conv_start_n));

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int DATA_W    = 12,
  parameter int CAP_W     = 24,
  parameter bit TWOS_COMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_evt,
  input  logic [CAP_W-1:0] raw,
  output logic [CAP_W-1:0] sample,
  output logic             sample_valid
);

  localparam logic [CAP_W-1:0] KEEP_MASK = CAP_W'((64'd1 << DATA_W) - 64'd1);
  localparam logic [CAP_W-1:0] SIGN_BIT  = CAP_W'(64'd1 << (DATA_W - 1));

  logic [CAP_W-1:0] masked, coded;

  assign masked = raw & KEEP_MASK;

  generate
    if (TWOS_COMP) begin : g_offset
      assign coded = masked ^ SIGN_BIT;
    end else begin : g_plain
      assign coded = masked;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sample       <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= cap_evt;
      if (cap_evt) sample <= coded;
    end
  end

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (sample & ~KEEP_MASK) == '0);

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             cap_evt,
  output logic             run_q,
  output logic             run_d,
  output logic             run_start,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] remain_q;
  logic accept, zero_req, end_evt, end_q;

  assign accept    = start && !busy;
  assign zero_req  = accept && (count == '0);
  assign run_start = accept && (count != '0);
  assign end_evt   = cap_evt && (remain_q == CNT_W'(1));

  always_comb begin
    run_d = run_q;
    if (run_start)    run_d = 1'b1;
    else if (end_evt) run_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      remain_q <= '0;
      end_q    <= 1'b0;
      done     <= 1'b0;
      busy     <= 1'b0;
    end else begin
      run_q <= run_d;
      if (run_start)    remain_q <= count;
      else if (cap_evt) remain_q <= remain_q - 1'b1;
      end_q <= end_evt;
      done  <= end_q || zero_req;
      busy  <= run_d || end_evt;
    end
  end

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy && run_q) |=> busy);

endmodule

// File: rtl/adc_strobe_seq.sv
module adc_strobe_seq #(
  parameter int DATA_W          = 12,
  parameter int CAP_W           = 24,
  parameter int CNT_W           = 20,
  parameter int TICK_DIV        = 1,
  parameter int CYCLE_STEPS     = 204,
  parameter int CONV_LOW_STEPS  = 4,
  parameter int CONV_TIME_STEPS = 165,
  parameter int READ_STEPS      = 3,
  parameter int STIM_DELAY      = 1,
  parameter int STIM_HIGH_STEPS = 100,
  parameter bit TWOS_COMP       = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] conv_count,
  input  logic [CAP_W-1:0] adc_data,
  output logic             conv_start_n,
  output logic             chip_sel_n,
  output logic             read_n,
  output logic             stim_clk,
  output logic [CAP_W-1:0] sample,
  output logic             sample_valid,
  output logic             busy,
  output logic             done
);

  logic tick, cap_evt, run_q, run_d, run_start;

  adc_seq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (!run_q),
    .tick (tick)
  );

  adc_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .count     (conv_count),
    .cap_evt   (cap_evt),
    .run_q     (run_q),
    .run_d     (run_d),
    .run_start (run_start),
    .busy      (busy),
    .done      (done)
  );

  adc_seq_timer #(
    .CYCLE_STEPS     (CYCLE_STEPS),
    .CONV_LOW_STEPS  (CONV_LOW_STEPS),
    .CONV_TIME_STEPS (CONV_TIME_STEPS),
    .READ_STEPS      (READ_STEPS),
    .STIM_DELAY      (STIM_DELAY),
    .STIM_HIGH_STEPS (STIM_HIGH_STEPS)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .run_q        (run_q),
    .run_d        (run_d),
    .run_start    (run_start),
    .cap_evt      (cap_evt),
    .conv_start_n (conv_start_n),
    .chip_sel_n   (chip_sel_n),
    .read_n       (read_n),
    .stim_clk     (stim_clk)
  );

  adc_seq_capture #(
    .DATA_W    (DATA_W),
    .CAP_W     (CAP_W),
    .TWOS_COMP (TWOS_COMP)
  ) u_capture (
    .clk          (clk),
    .rst          (rst),
    .cap_evt      (cap_evt),
    .raw          (adc_data),
    .sample       (sample),
    .sample_valid (sample_valid)
  );

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> conv_start_n && chip_sel_n && read_n && !stim_clk && !sample_valid);

  // R5
  valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> !$past(read_n) && read_n);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> conv_start_n && chip_sel_n && read_n && !stim_clk && !busy && !done);

endmodule

// File: tb/adc_strobe_seq_bench.sv
module adc_strobe_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [19:0] conv_count = '0;
  logic [23:0] adc_data = '0;
  logic        conv_start_n, chip_sel_n, read_n, stim_clk;
  logic [23:0] sample;
  logic        sample_valid, busy, done;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  adc_strobe_seq u_adc_strobe_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .conv_count   (conv_count),
    .adc_data     (adc_data),
    .conv_start_n (conv_start_n),
    .chip_sel_n   (chip_sel_n),
    .read_n       (read_n),
    .stim_clk     (stim_clk),
    .sample       (sample),
    .sample_valid (sample_valid),
    .busy         (busy),
    .done         (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      if (n_fail < 30)
        $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] word_for(input int mode, input int i);
    if (mode == 0) begin
      case (i % 4)
        0: return 24'hFFF800;
        1: return 24'hABC7FF;
        2: return 24'h5A5000;
        default: return 24'hC3CFFF;
      endcase
    end
    return 24'h000321 + 24'(i) * 24'h111111;
  endfunction

  function automatic logic [23:0] code_of(input logic [23:0] w);
    return (w & 24'h000FFF) ^ 24'h000800;
  endfunction

  task automatic check_idle(input string req);
    chk(conv_start_n === 1'b1, req, "conv_start_n idle", 32'(conv_start_n), 1);
    chk(chip_sel_n === 1'b1, req, "chip_sel_n idle", 32'(chip_sel_n), 1);
    chk(read_n === 1'b1, req, "read_n idle", 32'(read_n), 1);
    chk(stim_clk === 1'b0, req, "stim_clk idle", 32'(stim_clk), 0);
    chk(busy === 1'b0, req, "busy idle", 32'(busy), 0);
    chk(sample_valid === 1'b0, req, "valid idle", 32'(sample_valid), 0);
  endtask

  // Runs n conversions, comparing every output each clock with the expected waveform
  task automatic run_seq(input int n, input int mode, input bit poke_start, input string req);
    int last_v, total;
    last_v = 204 * (n - 1) + 172;
    total  = (n == 0) ? 8 : last_v + 6;
    @(negedge clk);
    conv_count = 20'(n);
    adc_data   = word_for(mode, 0);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < total; k++) begin
      int p, c;
      bit act, e_cs, e_valid;
      p = k % 204;
      c = k / 204;
      act = (n > 0) && (k < last_v);
      e_cs = act && p >= 169 && p < 172;
      e_valid = (n > 0) && (p == 172) && (k <= last_v);
      chk(conv_start_n === !(act && p < 4), "R2", "conv_start_n", 32'(conv_start_n), 32'(!(act && p < 4)));
      chk(chip_sel_n === !e_cs, "R3", "chip_sel_n", 32'(chip_sel_n), 32'(!e_cs));
      chk(read_n === !e_cs, "R3", "read_n", 32'(read_n), 32'(!e_cs));
      chk(stim_clk === (act && p >= 5 && p < 105), "R4", "stim_clk", 32'(stim_clk),
          32'(act && p >= 5 && p < 105));
      chk(sample_valid === e_valid, "R5", "sample_valid", 32'(sample_valid), 32'(e_valid));
      if (e_valid)
        chk(sample === code_of(word_for(mode, c)), "R6", "sample", 32'(sample),
            32'(code_of(word_for(mode, c))));
      chk(busy === ((n > 0) && k <= last_v), "R8", "busy", 32'(busy), 32'((n > 0) && k <= last_v));
      if (n == 0)
        chk(done === (k == 0), "R7", "done zero count", 32'(done), 32'(k == 0));
      else
        chk(done === (k == last_v + 1), "R8", "done", 32'(done), 32'(k == last_v + 1));
      // drive next word after the read window; poke start mid-run
      if (p == 180) adc_data = word_for(mode, c + 1);
      if (poke_start && k == 300) begin start = 1'b1; conv_count = 20'd7; end
      else start = 1'b0;
      @(negedge clk);
    end
    $display("%s run n=%0d done", req, n);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");
    chk(done === 1'b0, "R1", "done idle", 32'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");
  endtask

  task automatic t_single;   run_seq(1, 0, 1'b0, "R2"); check_idle("R1"); endtask
  task automatic t_multi;    run_seq(4, 0, 1'b0, "R7"); check_idle("R1"); endtask
  task automatic t_pattern;  run_seq(2, 1, 1'b0, "R6"); endtask
  task automatic t_zero;     run_seq(0, 0, 1'b0, "R7"); check_idle("R7"); endtask
  task automatic t_ignore;   run_seq(2, 1, 1'b1, "R9"); check_idle("R9"); endtask

  task automatic t_mid_reset;
    @(negedge clk);
    conv_count = 20'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (170) @(negedge clk);
    chk(read_n === 1'b0, "R10", "read_n low before reset", 32'(read_n), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle("R10");
    chk(done === 1'b0, "R10", "done after reset", 32'(done), 0);
    repeat (300) @(negedge clk);
    check_idle("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_pattern();
    t_zero();
    t_ignore();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule